// File: doc/BRIEF.md
# Serial Port Byte Buffers with Receive Trigger

This block holds bytes on both sides of a serial port. On the receive side, the deserializer pushes bytes in and the host pops them out. On the transmit side, the host pushes bytes in and the serializer pops them out. Both queues are first-word-fall-through: the oldest stored byte is always present on the read data output, and a pop strobe moves the queue on to the next byte.

Each side reports its fill level and its empty and full state. Each side also drives one interrupt line and one DMA request line:

- The receive interrupt means at least one byte is waiting.
- The transmit interrupt means the transmit queue has run dry.
- The transmit DMA request stays high while the transmit queue has room.
- The receive DMA request rises once the receive level reaches a threshold chosen by a 2-bit select. The host can therefore collect bytes in bursts instead of one at a time.

A dropped receive byte is recorded in a sticky overrun flag. Each side has a flush strobe that empties it in a single cycle.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset both queues hold zero bytes: levels read 0, both empty flags are 1, both full flags are 0, overrun is 0, the receive DMA request is 0, and the transmit interrupt and transmit DMA request are 1.
- R2: Bytes leave each queue in the order they were accepted. The read data output shows the oldest byte with no pop needed, and a pop on a non-empty queue exposes the next byte in the cycle after the pop edge.
- R3: Each queue holds 16 bytes and the full flag is high at level 16. A push to a full queue without a simultaneous pop is dropped and leaves the level and contents unchanged.
- R4: A dropped receive push sets the overrun output in the cycle after the edge. Overrun then stays at 1 until a receive flush clears it.
- R5: On a non-empty queue, a push and a pop in the same cycle leave the level unchanged; this includes a full queue, where the push is accepted. A pop on an empty queue is ignored. A simultaneous push and pop on an empty queue stores the byte.
- R6: A flush strobe empties its queue at the next edge (level 0, empty 1) and overrides any push or pop in that cycle. A receive flush also clears overrun.
- R7: The 2-bit receive threshold select is encoded as 00 = 1 byte, 01 = 4, 10 = 8 and 11 = 14. The receive DMA request is high exactly while the receive level is at or above the selected threshold.
- R8: The receive DMA request follows the level with no extra register stage. It drops in the same cycle that the level falls below the threshold, and it responds at once to a change of the select.
- R9: The receive interrupt equals "receive level nonzero". The transmit interrupt equals "transmit level zero". The transmit DMA request equals "transmit level below 16".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_push_i | input | 1 | Store rx_wdata_i into the receive queue |
| rx_wdata_i | input | 8 | Received byte from the deserializer |
| rx_pop_i | input | 1 | Host consumes the oldest receive byte |
| rx_flush_i | input | 1 | Empty the receive queue and clear overrun |
| rx_trig_sel_i | input | 2 | Receive threshold select (00=1, 01=4, 10=8, 11=14) |
| rx_rdata_o | output | 8 | Oldest receive byte |
| rx_level_o | output | 5 | Receive fill level |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_full_o | output | 1 | Receive queue full |
| rx_overrun_o | output | 1 | Sticky: a receive byte was dropped |
| rx_irq_o | output | 1 | Receive data waiting |
| rx_dma_req_o | output | 1 | Receive level at or above threshold |
| tx_push_i | input | 1 | Host stores tx_wdata_i into the transmit queue |
| tx_wdata_i | input | 8 | Byte to transmit |
| tx_pop_i | input | 1 | Serializer consumes the oldest transmit byte |
| tx_flush_i | input | 1 | Empty the transmit queue |
| tx_rdata_o | output | 8 | Oldest transmit byte |
| tx_level_o | output | 5 | Transmit fill level |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_full_o | output | 1 | Transmit queue full |
| tx_irq_o | output | 1 | Transmit queue empty |
| tx_dma_req_o | output | 1 | Transmit queue has room |

## Verification
Push and pop can land on the same edge, and so can a push and a flush. The bench provokes both on purpose.

The same-edge push and pop is driven in three states: partly full, full and empty. Each case is judged by the resulting level, by the byte now at the head of the queue and by the overrun flag. In the full case the byte that entered alongside the pop must reappear last when the queue is drained.

A flush arriving with a push must leave level 0. It must also clear overrun, which shows that flush outranks the store.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  typedef enum logic [1:0] {
    TRIG_ONE     = 2'b00,
    TRIG_QUARTER = 2'b01,
    TRIG_HALF    = 2'b10,
    TRIG_NEAR    = 2'b11
  } trig_sel_e;

  // threshold in bytes for a queue of the given depth
  function automatic int unsigned trig_bytes(input trig_sel_e sel, input int unsigned depth);
    case (sel)
      TRIG_ONE:     return 1;
      TRIG_QUARTER: return depth / 4;
      TRIG_HALF:    return depth / 2;
      default:      return depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] level_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (level_q == '0);
  assign full_o  = (level_q == LW'(DEPTH));
  assign do_pop  = pop_i && !empty_o && !flush_i;
  // a pop on a full queue frees the slot the push needs
  assign do_push = push_i && (!full_o || do_pop) && !flush_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
    end else if (flush_i) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_q];
  assign level_o = level_q;

  p_level_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LW'(DEPTH));
  p_full_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (full_o && $stable(rd_q)));
  p_pushpop_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && push_i && pop_i && !flush_i) |=> $stable(level_q));
  p_empty_pop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i && !flush_i) |=> empty_o);
  p_flush_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (empty_o && rd_q == wr_q));
endmodule

// File: rtl/rx_trigger.sv
module rx_trigger
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] level_i,
  input  logic [1:0]    trig_sel_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          flush_i,
  input  logic          full_i,
  output logic          req_o,
  output logic          overrun_o
);
  logic [LW-1:0] thr;
  logic          ovf_q;

  assign thr   = LW'(trig_bytes(trig_sel_e'(trig_sel_i), DEPTH));
  assign req_o = (level_i >= thr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ovf_q <= 1'b0;
    else if (flush_i)                       ovf_q <= 1'b0;
    else if (push_i && full_i && !pop_i)    ovf_q <= 1'b1;
  end
  assign overrun_o = ovf_q;

  p_ovf_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_i && !pop_i && !flush_i) |=> overrun_o);
  p_ovf_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !flush_i) |=> overrun_o);
  p_ovf_flush_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !overrun_o);
  p_req_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == '0) |-> !req_o);
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_wdata_i,
  input  logic          rx_pop_i,
  input  logic          rx_flush_i,
  input  logic [1:0]    rx_trig_sel_i,
  output logic [DW-1:0] rx_rdata_o,
  output logic [LW-1:0] rx_level_o,
  output logic          rx_empty_o,
  output logic          rx_full_o,
  output logic          rx_overrun_o,
  output logic          rx_irq_o,
  output logic          rx_dma_req_o,
  input  logic          tx_push_i,
  input  logic [DW-1:0] tx_wdata_i,
  input  logic          tx_pop_i,
  input  logic          tx_flush_i,
  output logic [DW-1:0] tx_rdata_o,
  output logic [LW-1:0] tx_level_o,
  output logic          tx_empty_o,
  output logic          tx_full_o,
  output logic          tx_irq_o,
  output logic          tx_dma_req_o
);
  byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push_i), .wdata_i(rx_wdata_i), .pop_i(rx_pop_i), .flush_i(rx_flush_i),
    .rdata_o(rx_rdata_o), .level_o(rx_level_o), .empty_o(rx_empty_o), .full_o(rx_full_o)
  );

  rx_trigger #(.DEPTH(DEPTH)) u_rx_trig (
    .clk_i, .rst_ni,
    .level_i(rx_level_o), .trig_sel_i(rx_trig_sel_i),
    .push_i(rx_push_i), .pop_i(rx_pop_i), .flush_i(rx_flush_i), .full_i(rx_full_o),
    .req_o(rx_dma_req_o), .overrun_o(rx_overrun_o)
  );

  byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push_i), .wdata_i(tx_wdata_i), .pop_i(tx_pop_i), .flush_i(tx_flush_i),
    .rdata_o(tx_rdata_o), .level_o(tx_level_o), .empty_o(tx_empty_o), .full_o(tx_full_o)
  );

  assign rx_irq_o     = !rx_empty_o;
  assign tx_irq_o     = tx_empty_o;
  assign tx_dma_req_o = !tx_full_o;

  p_irq_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o == (rx_level_o != '0));
  p_txirq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> (tx_level_o == '0 && tx_dma_req_o));
endmodule

// File: tb/uart_fifo_pair_bench.sv
module uart_fifo_pair_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       rx_push_i, rx_pop_i, rx_flush_i;
  logic [7:0] rx_wdata_i;
  logic [1:0] rx_trig_sel_i;
  logic [7:0] rx_rdata_o;
  logic [4:0] rx_level_o;
  logic       rx_empty_o, rx_full_o, rx_overrun_o, rx_irq_o, rx_dma_req_o;
  logic       tx_push_i, tx_pop_i, tx_flush_i;
  logic [7:0] tx_wdata_i;
  logic [7:0] tx_rdata_o;
  logic [4:0] tx_level_o;
  logic       tx_empty_o, tx_full_o, tx_irq_o, tx_dma_req_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  uart_fifo_pair u_uart_fifo_pair (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock: inputs already set; strobes cleared 1 ns after the edge
  task automatic cyc();
    @(posedge clk_i);
    #1;
    rx_push_i = 0; rx_pop_i = 0; rx_flush_i = 0;
    tx_push_i = 0; tx_pop_i = 0; tx_flush_i = 0;
  endtask

  // {push,pop,flush,trig[1:0],din[7:0],exp_lvl[4:0],exp_dma,exp_dout[7:0]}
  localparam int NV = 13;
  localparam logic [26:0] VEC [NV] = '{
    {3'b100, 2'b01, 8'hAA, 5'd1, 1'b0, 8'hAA},  // R2
    {3'b100, 2'b01, 8'hBB, 5'd2, 1'b0, 8'hAA},
    {3'b100, 2'b01, 8'hCC, 5'd3, 1'b0, 8'hAA},
    {3'b100, 2'b01, 8'hDD, 5'd4, 1'b1, 8'hAA},  // R7 level 4 >= 4
    {3'b110, 2'b01, 8'hEE, 5'd4, 1'b1, 8'hBB},  // R5 push+pop
    {3'b010, 2'b01, 8'h00, 5'd3, 1'b0, 8'hCC},  // R8 drops below
    {3'b000, 2'b00, 8'h00, 5'd3, 1'b1, 8'hCC},  // R8 select change
    {3'b010, 2'b10, 8'h00, 5'd2, 1'b0, 8'hDD},
    {3'b010, 2'b10, 8'h00, 5'd1, 1'b0, 8'hEE},
    {3'b010, 2'b00, 8'h00, 5'd0, 1'b0, 8'h00},
    {3'b010, 2'b00, 8'h00, 5'd0, 1'b0, 8'h00},  // R5 pop on empty
    {3'b110, 2'b00, 8'h11, 5'd1, 1'b1, 8'h11},  // R5 push+pop on empty
    {3'b101, 2'b00, 8'h22, 5'd0, 1'b0, 8'h00}   // R6 flush beats push
  };

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 0;
    rx_push_i = 0; rx_pop_i = 0; rx_flush_i = 0; rx_wdata_i = 0; rx_trig_sel_i = 0;
    tx_push_i = 0; tx_pop_i = 0; tx_flush_i = 0; tx_wdata_i = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1;
    #1;
    // R1 reset state
    chk("R1 rx_level", rx_level_o, 0);
    chk("R1 rx_empty", rx_empty_o, 1);
    chk("R1 rx_full", rx_full_o, 0);
    chk("R1 overrun", rx_overrun_o, 0);
    chk("R1 rx_dma", rx_dma_req_o, 0);
    chk("R1 rx_irq", rx_irq_o, 0);
    chk("R1 tx_level", tx_level_o, 0);
    chk("R1 tx_irq", tx_irq_o, 1);
    chk("R1 tx_dma", tx_dma_req_o, 1);
    chk("R1 tx_full", tx_full_o, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {rx_push_i, rx_pop_i, rx_flush_i} = VEC[i][26:24];
      rx_trig_sel_i = VEC[i][23:22];
      rx_wdata_i    = VEC[i][21:14];
      cyc();
      chk("R2/R5/R6 level", rx_level_o, VEC[i][13:9]);
      chk("R7/R8 rx_dma", rx_dma_req_o, VEC[i][8]);
      chk("R9 rx_irq", rx_irq_o, VEC[i][13:9] != 0);
      if (VEC[i][13:9] != 0) chk("R2 head byte", rx_rdata_o, VEC[i][7:0]);
    end

    // fill receive queue to full with threshold 14
    rx_trig_sel_i = 2'b11;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk_i); rx_push_i = 1; rx_wdata_i = 8'h40 + 8'(k); cyc();
      if (k == 12) chk("R7 below 14", rx_dma_req_o, 0);
      if (k == 13) chk("R7 at 14", rx_dma_req_o, 1);
    end
    chk("R3 full flag", rx_full_o, 1);
    chk("R3 level 16", rx_level_o, 16);
    @(negedge clk_i); rx_push_i = 1; rx_wdata_i = 8'hEE; cyc();
    chk("R3 drop level", rx_level_o, 16);
    chk("R3 drop head", rx_rdata_o, 8'h40);
    chk("R4 overrun set", rx_overrun_o, 1);
    @(negedge clk_i); rx_push_i = 1; rx_pop_i = 1; rx_wdata_i = 8'hEF; cyc();
    chk("R5 full push+pop level", rx_level_o, 16);
    chk("R5 full push+pop head", rx_rdata_o, 8'h41);
    chk("R4 overrun held", rx_overrun_o, 1);
    for (int k = 0; k < 16; k++) begin
      chk("R2 drain order", rx_rdata_o, (k < 15) ? 8'h41 + 8'(k) : 8'hEF);
      @(negedge clk_i); rx_pop_i = 1; cyc();
      if (k == 2) chk("R8 drop at 13", rx_dma_req_o, 0);
    end
    chk("R2 drained empty", rx_empty_o, 1);
    chk("R4 overrun sticky", rx_overrun_o, 1);
    @(negedge clk_i); rx_flush_i = 1; cyc();
    chk("R6 overrun cleared", rx_overrun_o, 0);

    // transmit side
    for (int k = 0; k < 16; k++) begin
      @(negedge clk_i); tx_push_i = 1; tx_wdata_i = 8'h80 + 8'(k); cyc();
      if (k == 0) chk("R9 tx_irq off", tx_irq_o, 0);
    end
    chk("R3 tx full", tx_full_o, 1);
    chk("R9 tx_dma off", tx_dma_req_o, 0);
    @(negedge clk_i); tx_push_i = 1; tx_wdata_i = 8'hFF; cyc();
    chk("R3 tx drop", tx_level_o, 16);
    chk("R3 tx head", tx_rdata_o, 8'h80);
    @(negedge clk_i); tx_pop_i = 1; cyc();
    chk("R9 tx_dma back", tx_dma_req_o, 1);
    chk("R2 tx next", tx_rdata_o, 8'h81);
    @(negedge clk_i); tx_flush_i = 1; tx_push_i = 1; cyc();
    chk("R6 tx flush", tx_level_o, 0);
    chk("R9 tx_irq on", tx_irq_o, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule